// File: doc/BRIEF.md
# Machine Cycle and Peripheral Clock Enable Generator

This block runs on the oscillator clock and derives a set of single-cycle enable strobes from it: one for the machine cycle, one for each general-purpose timer, one for the timer 2 clock and baud generator, and one each for the two fixed-rate serial port modes (mode 0 and mode 2). Downstream logic stays on the oscillator clock and advances only in cycles where its strobe is high. No divided clocks are generated.

The strobe periods depend on the clock mode (2x multiplier, 4x multiplier, divide-by-4 or power management) and on each consumer's speed-select input. In power management mode every rate is stretched by a fixed large factor rather than by plain scaling. A change to any control input waits for the end of the current machine cycle before it takes effect. Every divider then starts over, so no strobe comes early or twice.

Top module: `mcyc_clk_en`

## Requirements
- R1: Clock mode `clk_mode_i` encodes 00 = multiplier, 10 = divide-by-4, 11 = power management. The `mc_en_o` period in oscillator cycles is 2 for the multiplier with `mult4_i`=0, 1 for the multiplier with `mult4_i`=1, 4 for divide-by-4 and 1024 for power management.
- R2: The reserved mode code 01 behaves exactly like divide-by-4 for every output.
- R3: When bit i of `tmr_fast_i` is 1, `tmr_en_o[i]` has the same period as `mc_en_o` and is high in the same cycles.
- R4: When bit i of `tmr_fast_i` is 0, the `tmr_en_o[i]` period is 12 in every mode except power management, where it is 3072.
- R5: The `baud_en_o` period is 2 in every mode except power management, where it is 512.
- R6: With `sm2_i`=0 the `ser0_en_o` period is 6, 3, 12 or 3072 for 2x, 4x, divide-by-4 and power management respectively. With `sm2_i`=1 it equals the machine cycle period and is high in the same cycles as `mc_en_o`.
- R7: The `ser2_en_o` period is 64 (`smod_i`=0) or 32 (`smod_i`=1) outside power management, and 16384 or 8192 in power management.
- R8: For a period above 1, each enable is high for exactly one oscillator cycle per period. For a period of 1 it is high in every cycle.
- R9: An input change is taken only on the clock edge that ends a cycle with `mc_en_o` high. The machine cycle in progress runs to its full old length. On that edge all dividers restart, so each output's first pulse comes a full new period later.
- R10: While `rst_ni` is low all enables are low and the configuration is divide-by-4 with all selects 0. After release, the first `mc_en_o` pulse is seen in the third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_mode_i | input | 2 | Clock mode: 00 multiplier, 01 reserved, 10 divide-by-4, 11 power management |
| mult4_i | input | 1 | Multiplier select: 1 = 4x, 0 = 2x |
| tmr_fast_i | input | NUM_TMR | Per-timer select: 1 = machine-cycle rate, 0 = slow rate |
| sm2_i | input | 1 | Serial mode 0 select: 1 = machine-cycle rate |
| smod_i | input | 1 | Serial mode 2 rate doubler |
| mc_en_o | output | 1 | Machine cycle strobe |
| tmr_en_o | output | NUM_TMR | Per-timer count strobes |
| baud_en_o | output | 1 | Timer 2 clock / baud generator strobe |
| ser0_en_o | output | 1 | Serial mode 0 shift strobe |
| ser2_en_o | output | 1 | Serial mode 2 bit strobe |

## Verification
The bench applies configurations that cover all four clock modes and the reserved code, with mixed per-timer selects so that fast and slow timers run side by side and the per-bit routing is visible. Each configuration is paired with both settings of the serial selects, which separates the machine-cycle-tracking path from the fixed-ratio path and the power-management stretch factors from ordinary scaling. It measures every output's pulse spacing and compares the spacing against periods computed from the mode table. A mid-cycle switch out of power management checks that the old machine cycle is not cut short and that a slow divider restarts from zero.

// File: rtl/mce_pkg.sv
package mce_pkg;

  typedef enum logic [1:0] {
    MODE_MULT = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_DIV4 = 2'b10,
    MODE_PMM  = 2'b11
  } clk_mode_e;

  typedef struct packed {
    clk_mode_e mode;
    logic      mult4;
    logic      sm2;
    logic      smod;
  } cfg_t;

  // oscillator cycles per strobe
  localparam int MC_MULT2   = 2;
  localparam int MC_MULT4   = 1;
  localparam int MC_DIV4    = 4;
  localparam int MC_PMM     = 1024;
  localparam int TMR_SLOW   = 12;
  localparam int TMR_PMM    = 3072;
  localparam int BAUD_STD   = 2;
  localparam int BAUD_PMM   = 512;
  localparam int SER0_MULT2 = 6;
  localparam int SER0_MULT4 = 3;
  localparam int SER0_DIV4  = 12;
  localparam int SER0_PMM   = 3072;
  localparam int SER2_STD   = 64;
  localparam int SER2_PMM   = 16384;

  localparam int CNT_W = $clog2(SER2_PMM + 1);

  // strobe index map; timers follow the fixed strobes
  localparam int EN_MC    = 0;
  localparam int EN_BAUD  = 1;
  localparam int EN_SER0  = 2;
  localparam int EN_SER2  = 3;
  localparam int EN_FIXED = 4;

  localparam cfg_t CFG_RESET = '{mode: MODE_DIV4, mult4: 1'b0, sm2: 1'b0, smod: 1'b0};

endpackage

// File: rtl/mce_cfg_reg.sv
module mce_cfg_reg
  import mce_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cfg_t               cfg_i,
  input  logic [NUM_TMR-1:0] fast_i,
  input  logic               apply_i,
  output cfg_t               cfg_o,
  output logic [NUM_TMR-1:0] fast_o,
  output logic               restart_o
);

  cfg_t cfg_n, cfg_q;
  logic [NUM_TMR-1:0] fast_q;

  always_comb begin
    cfg_n = cfg_i;
    if (cfg_i.mode == MODE_RSVD) cfg_n.mode = MODE_DIV4;
  end

  assign restart_o = apply_i && ((cfg_n != cfg_q) || (fast_i != fast_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RESET;
      fast_q <= '0;
    end else if (apply_i) begin
      cfg_q  <= cfg_n;
      fast_q <= fast_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign fast_o = fast_q;

endmodule

// File: rtl/mce_period_sel.sv
module mce_period_sel
  import mce_pkg::*;
#(
  parameter int NUM_TMR = 3,
  localparam int NumEn  = EN_FIXED + NUM_TMR
) (
  input  cfg_t                          cfg_i,
  input  logic [NUM_TMR-1:0]            fast_i,
  output logic [NumEn-1:0][CNT_W-1:0]   period_o
);

  logic             pmm;
  logic [CNT_W-1:0] mc_p;

  assign pmm = (cfg_i.mode == MODE_PMM);

  always_comb begin
    unique case (cfg_i.mode)
      MODE_MULT: mc_p = cfg_i.mult4 ? CNT_W'(MC_MULT4) : CNT_W'(MC_MULT2);
      MODE_PMM:  mc_p = CNT_W'(MC_PMM);
      default:   mc_p = CNT_W'(MC_DIV4);
    endcase
  end

  always_comb begin
    period_o[EN_MC]   = mc_p;
    period_o[EN_BAUD] = pmm ? CNT_W'(BAUD_PMM) : CNT_W'(BAUD_STD);

    if (cfg_i.sm2) period_o[EN_SER0] = mc_p;
    else begin
      unique case (cfg_i.mode)
        MODE_MULT: period_o[EN_SER0] = cfg_i.mult4 ? CNT_W'(SER0_MULT4) : CNT_W'(SER0_MULT2);
        MODE_PMM:  period_o[EN_SER0] = CNT_W'(SER0_PMM);
        default:   period_o[EN_SER0] = CNT_W'(SER0_DIV4);
      endcase
    end

    // smod halves the mode-2 period
    period_o[EN_SER2] = (pmm ? CNT_W'(SER2_PMM) : CNT_W'(SER2_STD)) >> cfg_i.smod;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign period_o[EN_FIXED+i] = fast_i[i] ? mc_p
                                : (pmm ? CNT_W'(TMR_PMM) : CNT_W'(TMR_SLOW));
  end

endmodule

// File: rtl/mce_div.sv
module mce_div #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             en_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = period_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q >= last)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign en_o = (cnt_q == last);

endmodule

// File: rtl/mcyc_clk_en.sv
module mcyc_clk_en
  import mce_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         clk_mode_i,
  input  logic               mult4_i,
  input  logic [NUM_TMR-1:0] tmr_fast_i,
  input  logic               sm2_i,
  input  logic               smod_i,
  output logic               mc_en_o,
  output logic [NUM_TMR-1:0] tmr_en_o,
  output logic               baud_en_o,
  output logic               ser0_en_o,
  output logic               ser2_en_o
);

  localparam int NumEn = EN_FIXED + NUM_TMR;

  cfg_t                        cfg_in, cfg_q;
  logic [NUM_TMR-1:0]          fast_q;
  logic                        restart;
  logic [NumEn-1:0][CNT_W-1:0] period;
  logic [NumEn-1:0]            en;
  logic [CNT_W-1:0]            mc_period;

  assign cfg_in = '{mode: clk_mode_e'(clk_mode_i), mult4: mult4_i, sm2: sm2_i, smod: smod_i};

  mce_cfg_reg #(.NUM_TMR(NUM_TMR)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_in),
    .fast_i    (tmr_fast_i),
    .apply_i   (en[EN_MC]),
    .cfg_o     (cfg_q),
    .fast_o    (fast_q),
    .restart_o (restart)
  );

  mce_period_sel #(.NUM_TMR(NUM_TMR)) u_sel (
    .cfg_i    (cfg_q),
    .fast_i   (fast_q),
    .period_o (period)
  );

  for (genvar i = 0; i < NumEn; i++) begin : g_div
    mce_div #(.CNT_W(CNT_W)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .period_i  (period[i]),
      .en_o      (en[i])
    );
  end

  assign mc_period = period[EN_MC];
  assign mc_en_o   = en[EN_MC];
  assign baud_en_o = en[EN_BAUD];
  assign ser0_en_o = en[EN_SER0];
  assign ser2_en_o = en[EN_SER2];
  assign tmr_en_o  = en[EN_FIXED +: NUM_TMR];

endmodule

// File: rtl/mce_chk.sv
module mce_chk
  import mce_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input cfg_t               cfg_q,
  input logic [NUM_TMR-1:0] fast_q,
  input logic [CNT_W-1:0]   mc_period,
  input logic               mc_en,
  input logic [NUM_TMR-1:0] tmr_en,
  input logic               baud_en,
  input logic               ser0_en,
  input logic               ser2_en
);

  a_r9_cfg_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_q != $past(cfg_q)) || (fast_q != $past(fast_q))) |-> $past(mc_en));

  a_r8_mc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_en && mc_period > CNT_W'(1)) |=> (!mc_en || mc_period == CNT_W'(1)));

  a_r5_baud_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_en |=> !baud_en);

  a_r7_ser2_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser2_en |=> !ser2_en);

  a_r6_sm2_tracks_mc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.sm2 |-> (ser0_en == mc_en));

  a_r2_no_reserved_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.mode != MODE_RSVD);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    a_r3_fast_tracks_mc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fast_q[i] |-> (tmr_en[i] == mc_en));
  end

endmodule

bind mcyc_clk_en mce_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_q     (cfg_q),
  .fast_q    (fast_q),
  .mc_period (mc_period),
  .mc_en     (mc_en_o),
  .tmr_en    (tmr_en_o),
  .baud_en   (baud_en_o),
  .ser0_en   (ser0_en_o),
  .ser2_en   (ser2_en_o)
);

// File: tb/mcyc_clk_en_test.sv
module mcyc_clk_en_test;

  localparam int NT = 3;
  localparam int NE = 4 + NT;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    clk_mode_i = 2'b10;
  logic          mult4_i = 1'b0;
  logic [NT-1:0] tmr_fast_i = '0;
  logic          sm2_i = 1'b0;
  logic          smod_i = 1'b0;
  logic          mc_en_o, baud_en_o, ser0_en_o, ser2_en_o;
  logic [NT-1:0] tmr_en_o;

  always #2.5 clk_i = ~clk_i;

  mcyc_clk_en #(.NUM_TMR(NT)) uut (
    .clk_i, .rst_ni, .clk_mode_i, .mult4_i, .tmr_fast_i, .sm2_i, .smod_i,
    .mc_en_o, .tmr_en_o, .baud_en_o, .ser0_en_o, .ser2_en_o
  );

  // bench index: 0 mc, 1 baud, 2 ser0, 3 ser2, 4.. timers
  logic [NE-1:0] en_vec;
  assign en_vec = {tmr_en_o, ser2_en_o, ser0_en_o, baud_en_o, mc_en_o};

  typedef struct {
    int    idx;
    int    period;
    string req;
  } exp_t;

  exp_t sb_q[$];
  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int idx, int p, string req);
    exp_t e;
    e.idx = idx; e.period = p; e.req = req;
    sb_q.push_back(e);
  endtask

  // driver: applies inputs, waits for the boundary, predicts periods
  task automatic drive(logic [1:0] mode, logic m4, logic [NT-1:0] fast, logic s2, logic sm);
    int mc, t_slow, baud, s0, s2p;
    logic pmm;
    logic [1:0] m;
    clk_mode_i = mode; mult4_i = m4; tmr_fast_i = fast; sm2_i = s2; smod_i = sm;
    while (!mc_en_o) @(negedge clk_i);
    @(negedge clk_i);
    m   = (mode == 2'b01) ? 2'b10 : mode;
    pmm = (m == 2'b11);
    case (m)
      2'b00:   begin mc = m4 ? 1 : 2; s0 = m4 ? 3 : 6; end
      2'b11:   begin mc = 1024; s0 = 3072; end
      default: begin mc = 4; s0 = 12; end
    endcase
    if (s2) s0 = mc;
    t_slow = pmm ? 3072 : 12;
    baud   = pmm ? 512 : 2;
    s2p    = pmm ? (sm ? 8192 : 16384) : (sm ? 32 : 64);
    push(0, mc, (mode == 2'b01) ? "R2 mc" : "R1 mc");
    push(1, baud, "R5 baud");
    push(2, s0, s2 ? "R6 ser0 sm2=1" : "R6 ser0 sm2=0");
    push(3, s2p, "R7 ser2");
    for (int i = 0; i < NT; i++)
      push(4 + i, fast[i] ? mc : t_slow, fast[i] ? "R3 fast timer" : "R4 slow timer");
  endtask

  // monitor: measures spacing of every strobe, pops and compares
  task automatic monitor();
    int gap[NE];
    int seen[NE];
    int last[NE];
    int t = 0;
    bit done = 1'b0;
    exp_t e;
    for (int k = 0; k < NE; k++) begin gap[k] = -1; seen[k] = 0; last[k] = 0; end
    while (!done && t < 40000) begin
      @(negedge clk_i);
      t++;
      for (int k = 0; k < NE; k++) begin
        if (en_vec[k]) begin
          if (seen[k] == 1) gap[k] = t - last[k];
          seen[k]++;
          last[k] = t;
        end
      end
      done = 1'b1;
      for (int k = 0; k < NE; k++) if (seen[k] < 2) done = 1'b0;
    end
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(e.req, gap[e.idx], e.period);
    end
  endtask

  task automatic count_high(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (mc_en_o) hits++;
    end
  endtask

  initial begin
    int n, hits, a, b;
    repeat (3) @(negedge clk_i);
    check("R10 reset enables low", int'(en_vec), 0);
    rst_ni = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!mc_en_o && n < 50);
    check("R10 first mc pulse", n, 3);

    drive(2'b10, 1'b0, 3'b000, 1'b0, 1'b0); monitor();
    count_high(40, hits);
    check("R8 one cycle per period div4", hits, 10);
    drive(2'b10, 1'b0, 3'b101, 1'b1, 1'b1); monitor();
    drive(2'b00, 1'b0, 3'b010, 1'b0, 1'b0); monitor();
    drive(2'b00, 1'b1, 3'b111, 1'b1, 1'b1); monitor();
    count_high(10, hits);
    check("R8 period 1 always high", hits, 10);
    drive(2'b00, 1'b1, 3'b000, 1'b0, 1'b0); monitor();
    drive(2'b11, 1'b0, 3'b001, 1'b0, 1'b1); monitor();

    // R9: switch out of power management mid machine cycle
    while (!mc_en_o) @(negedge clk_i);
    repeat (100) @(negedge clk_i);
    clk_mode_i = 2'b10; tmr_fast_i = '0; sm2_i = 1'b0; smod_i = 1'b0;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!mc_en_o && n < 5000);
    check("R9 old machine cycle kept", n, 924);
    a = -1; b = -1;
    for (int t = 1; t <= 200; t++) begin
      @(negedge clk_i);
      if (mc_en_o && a < 0) a = t;
      if (ser2_en_o && b < 0) b = t;
    end
    check("R9 first new mc pulse", a, 4);
    check("R9 ser2 restarted", b, 64);

    drive(2'b01, 1'b0, 3'b000, 1'b1, 1'b0); monitor();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule